// File: doc/BRIEF.md
# Character LCD Host Interface Controller

This block is the processor-side port of a character dot-matrix display controller. A host performs one access per cycle. Each access is qualified by a valid strobe and carries a register-select bit, a read/write bit and an 8-bit bus. Register-select low addresses the instruction side and register-select high addresses the data side. The block keeps a 7-bit address counter. The counter targets either a display-data store or a character-pattern store, and the most recent address-set instruction decides which.

Data writes go to the selected store at the counter and then step the counter. Data reads are served from a prefetched output register. That register is refilled when an address is set, when the cursor is shifted on the display store, and after every read. Because a write does not refill it, a read that directly follows writes returns stale data. The counter follows the two-line address map and jumps across the gap between the lines.

A busy indication rises for a fixed number of cycles after each accepted write. Writes presented while it is high are discarded.

Top module: `lcdh_host_if`

## Requirements
- R1: After reset, busy is 0, the address counter is 0x00, the display store is the target, the step direction is upward, one-line mode is active and the output data register holds 0x00. A status read therefore returns 0x00.
- R2: A status read (select 0, read 1) returns the busy flag in bit 7 and the address counter in bits 6:0. It changes no state.
- R3: An instruction write with bit 7 set loads the counter from bits 6:0 and targets the display store. An instruction write with bits 7:6 = 01 loads the counter from bits 5:0, with counter bit 6 cleared, and targets the pattern store. Both load the output data register from the newly addressed entry.
- R4: A data write (select 1, read 0) stores the bus into the targeted store at the counter, then steps the counter.
- R5: An instruction write with bits 7:2 = 000001 sets the step direction from bit 1: 1 steps upward, 0 steps downward. The direction applies to the steps of later data reads and writes.
- R6: An instruction write with bits 7:5 = 001 sets the line mode from bit 3 (1 = two lines). In two-line mode the display counter steps up 0x27→0x40 and 0x67→0x00, and steps down 0x40→0x27 and 0x00→0x67. Other values step by one.
- R7: In one-line mode the display counter steps within 0x00..0x4F, wrapping 0x4F→0x00 upward and 0x00→0x4F downward.
- R8: While the pattern store is targeted, the counter steps modulo 64 and bit 6 stays 0.
- R9: A data read (select 1, read 1) returns the output data register. It then steps the counter and reloads the register from the targeted store at the stepped address.
- R10: A data write does not reload the output data register, so a read after writes returns the value latched before them.
- R11: An instruction write with bits 7:4 = 0001 and bit 3 = 0 moves the counter one step, upward when bit 2 is 1 and downward when it is 0, regardless of the entry direction. When the display store is targeted, it also reloads the output data register. With bit 3 = 1 the counter is unchanged.
- R12: Any write accepted while busy is 0 raises busy from the next cycle for exactly BUSY_CYC cycles. Reads never raise it.
- R13: Writes presented while busy is 1 are discarded: the counter, the target and the stores are unchanged, and busy is not extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | Host access strobe, one access per cycle |
| acc_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| acc_rw | input | 1 | 1 read, 0 write |
| acc_wdata | input | 8 | Write bus |
| acc_rdata | output | 8 | Read bus, valid in the cycle of a read access, 0 otherwise |
| busy | output | 1 | Internal operation in progress |

## Verification
The range properties assume the host sets only addresses that are valid for the current line mode. They also assume the host re-sets the address before it changes the line mode, so the counter never sits in a gap of the map. The bench complies: every address it sets lies inside a line, and it moves the counter to 0x00 before each mode change. The busy and discard properties assume nothing about the host. The bench deliberately presents writes while busy to exercise them.

// File: rtl/lcdh_pkg.sv
package lcdh_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_STATUS,
    OP_RD,
    OP_WR,
    OP_SET_DD,
    OP_SET_CG,
    OP_ENTRY,
    OP_FUNC,
    OP_SHIFT,
    OP_OTHER
  } op_e;

  typedef struct packed {
    op_e        op;
    logic       arg_a;  // entry dir / line mode / shift-vs-move
    logic       arg_b;  // shift direction
    logic [6:0] addr;
  } cmd_t;

endpackage

// File: rtl/lcdh_rst_sync.sv
module lcdh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/lcdh_decode.sv
module lcdh_decode
  import lcdh_pkg::*;
(
  input  logic       vld,
  input  logic       rs,
  input  logic       rw,
  input  logic [7:0] wdata,
  output cmd_t       cmd
);
  always_comb begin
    cmd.op    = OP_NONE;
    cmd.arg_a = 1'b0;
    cmd.arg_b = 1'b0;
    cmd.addr  = wdata[6:0];
    if (vld) begin
      if (rs) begin
        cmd.op = rw ? OP_RD : OP_WR;
      end else if (rw) begin
        cmd.op = OP_STATUS;
      end else begin
        casez (wdata)
          8'b1???????: cmd.op = OP_SET_DD;
          8'b01??????: cmd.op = OP_SET_CG;
          8'b001?????: begin
            cmd.op    = OP_FUNC;
            cmd.arg_a = wdata[3];
          end
          8'b0001????: begin
            cmd.op    = OP_SHIFT;
            cmd.arg_a = wdata[3];
            cmd.arg_b = wdata[2];
          end
          8'b000001??: begin
            cmd.op    = OP_ENTRY;
            cmd.arg_a = wdata[1];
          end
          default: cmd.op = OP_OTHER;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcdh_addr_step.sv
module lcdh_addr_step #(
  parameter int AW         = 7,
  parameter int CW         = 6,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64
) (
  input  logic [AW-1:0] ac,
  input  logic          up,
  input  logic          cg,
  input  logic          two_line,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] ZERO    = '0;
  localparam logic [AW-1:0] ONE     = AW'(1);
  localparam logic [AW-1:0] L1_END  = AW'(LINE_LEN - 1);
  localparam logic [AW-1:0] L2_BEG  = AW'(LINE2_BASE);
  localparam logic [AW-1:0] L2_END  = AW'(LINE2_BASE + LINE_LEN - 1);
  localparam logic [AW-1:0] ONE_END = AW'(2 * LINE_LEN - 1);
  localparam logic [CW-1:0] CG_ONE  = CW'(1);

  logic [CW-1:0] cg_nxt;

  always_comb begin
    cg_nxt = up ? (ac[CW-1:0] + CG_ONE) : (ac[CW-1:0] - CG_ONE);
    if (cg) begin
      nxt = AW'(cg_nxt);
    end else if (two_line) begin
      if (up) begin
        if (ac == L1_END)      nxt = L2_BEG;
        else if (ac == L2_END) nxt = ZERO;
        else                   nxt = ac + ONE;
      end else begin
        if (ac == L2_BEG)      nxt = L1_END;
        else if (ac == ZERO)   nxt = L2_END;
        else                   nxt = ac - ONE;
      end
    end else begin
      if (up) nxt = (ac == ONE_END) ? ZERO : ac + ONE;
      else    nxt = (ac == ZERO) ? ONE_END : ac - ONE;
    end
  end
endmodule

// File: rtl/lcdh_regfile.sv
module lcdh_regfile #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lcdh_busy.sv
module lcdh_busy #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNTW = $clog2(CYC + 1);
  localparam logic [CNTW-1:0] LOAD = CNTW'(CYC);
  localparam logic [CNTW-1:0] DEC  = CNTW'(1);

  logic [CNTW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)            cnt_d = LOAD;
    else if (cnt_q != '0) cnt_d = cnt_q - DEC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/lcdh_host_if.sv
module lcdh_host_if
  import lcdh_pkg::*;
#(
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64,
  parameter int CG_DEPTH   = 64,
  parameter int BUSY_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_vld,
  input  logic       acc_rs,
  input  logic       acc_rw,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  output logic       busy
);
  localparam int DW       = 8;
  localparam int AW       = DW - 1;
  localparam int CW       = $clog2(CG_DEPTH);
  localparam int DD_DEPTH = 2 * LINE_LEN;
  localparam int DIW      = $clog2(DD_DEPTH);
  localparam logic [AW-1:0] L1_LEN  = AW'(LINE_LEN);
  localparam logic [AW-1:0] L2_BEG  = AW'(LINE2_BASE);
  localparam logic [AW-1:0] L2_END  = AW'(LINE2_BASE + LINE_LEN - 1);
  localparam logic [AW-1:0] ONE_END = AW'(DD_DEPTH - 1);

  logic rst_s;
  lcdh_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  // architectural state
  logic [AW-1:0] ac_q, ac_d;
  logic          cg_q, cg_d;
  logic          up_q, up_d;
  logic          two_q, two_d;
  logic [DW-1:0] odr_q, odr_d;

  cmd_t cmd;
  lcdh_decode u_dec (
    .vld(acc_vld), .rs(acc_rs), .rw(acc_rw), .wdata(acc_wdata), .cmd(cmd)
  );

  logic          step_dir;
  logic [AW-1:0] ac_step;
  assign step_dir = (cmd.op == OP_SHIFT) ? cmd.arg_b : up_q;

  lcdh_addr_step #(
    .AW(AW), .CW(CW), .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE)
  ) u_step (
    .ac(ac_q), .up(step_dir), .cg(cg_q), .two_line(two_q), .nxt(ac_step)
  );

  // logical display address -> {valid, physical index}
  function automatic logic [DIW:0] dd_map(input logic [AW-1:0] a, input logic two);
    logic [DIW:0] r;
    r = '0;
    if (two) begin
      if (a < L1_LEN)                   r = {1'b1, DIW'(a)};
      else if (a >= L2_BEG && a <= L2_END)
        r = {1'b1, DIW'(AW'(a - L2_BEG + L1_LEN))};
    end else if (a <= ONE_END) begin
      r = {1'b1, DIW'(a)};
    end
    return r;
  endfunction

  logic          busy_go, wr_en, ld_odr, rd_cg;
  logic [AW-1:0] rd_addr;
  logic          wr_ok;
  assign wr_ok = !busy;

  always_comb begin
    ac_d    = ac_q;
    cg_d    = cg_q;
    up_d    = up_q;
    two_d   = two_q;
    busy_go = 1'b0;
    wr_en   = 1'b0;
    ld_odr  = 1'b0;
    rd_cg   = cg_q;
    rd_addr = ac_step;
    unique case (cmd.op)
      OP_RD: begin
        ac_d   = ac_step;
        ld_odr = 1'b1;
      end
      OP_WR: if (wr_ok) begin
        busy_go = 1'b1;
        wr_en   = 1'b1;
        ac_d    = ac_step;
      end
      OP_SET_DD: if (wr_ok) begin
        busy_go = 1'b1;
        ac_d    = cmd.addr;
        cg_d    = 1'b0;
        rd_cg   = 1'b0;
        rd_addr = cmd.addr;
        ld_odr  = 1'b1;
      end
      OP_SET_CG: if (wr_ok) begin
        busy_go = 1'b1;
        ac_d    = AW'(cmd.addr[CW-1:0]);
        cg_d    = 1'b1;
        rd_cg   = 1'b1;
        rd_addr = AW'(cmd.addr[CW-1:0]);
        ld_odr  = 1'b1;
      end
      OP_ENTRY: if (wr_ok) begin
        busy_go = 1'b1;
        up_d    = cmd.arg_a;
      end
      OP_FUNC: if (wr_ok) begin
        busy_go = 1'b1;
        two_d   = cmd.arg_a;
      end
      OP_SHIFT: if (wr_ok) begin
        busy_go = 1'b1;
        if (!cmd.arg_a) begin
          ac_d = ac_step;
          if (!cg_q) begin
            ld_odr = 1'b1;
            rd_cg  = 1'b0;
          end
        end
      end
      OP_OTHER: if (wr_ok) busy_go = 1'b1;
      default: ;
    endcase
  end

  // storage
  logic [DIW:0]    dd_rmap, dd_wmap;
  logic [DW-1:0]   dd_rd, cg_rd;
  assign dd_rmap = dd_map(rd_addr, two_q);
  assign dd_wmap = dd_map(ac_q, two_q);

  lcdh_regfile #(.DEPTH(DD_DEPTH), .W(DW), .IW(DIW)) u_ddram (
    .clk(clk),
    .we(wr_en && !cg_q && dd_wmap[DIW]),
    .waddr(dd_wmap[DIW-1:0]),
    .wdata(acc_wdata),
    .raddr(dd_rmap[DIW-1:0]),
    .rdata(dd_rd)
  );

  lcdh_regfile #(.DEPTH(CG_DEPTH), .W(DW), .IW(CW)) u_cgram (
    .clk(clk),
    .we(wr_en && cg_q),
    .waddr(ac_q[CW-1:0]),
    .wdata(acc_wdata),
    .raddr(rd_addr[CW-1:0]),
    .rdata(cg_rd)
  );

  always_comb begin
    odr_d = odr_q;
    if (ld_odr) begin
      if (rd_cg)              odr_d = cg_rd;
      else if (dd_rmap[DIW])  odr_d = dd_rd;
      else                    odr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ac_q  <= '0;
      cg_q  <= 1'b0;
      up_q  <= 1'b1;
      two_q <= 1'b0;
      odr_q <= '0;
    end else if (acc_vld) begin
      ac_q  <= ac_d;
      cg_q  <= cg_d;
      up_q  <= up_d;
      two_q <= two_d;
      odr_q <= odr_d;
    end
  end

  lcdh_busy #(.CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst_n(rst_s), .start(busy_go), .busy(busy)
  );

  always_comb begin
    acc_rdata = '0;
    if (acc_vld && acc_rw) acc_rdata = acc_rs ? odr_q : {busy, ac_q};
  end
endmodule

// File: rtl/lcdh_host_if_chk.sv
module lcdh_host_if_chk #(
  parameter int BUSY_CYC   = 4,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_vld,
  input logic       acc_rs,
  input logic       acc_rw,
  input logic       busy,
  input logic [6:0] ac,
  input logic       cg_sel,
  input logic       two_line
);
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 16'd1;
    else           run_q <= '0;
  end

  p_accept_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && !acc_rw && !busy |=> busy);

  p_busy_max_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_q < 16'(BUSY_CYC));

  p_busy_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == 16'(BUSY_CYC));

  p_drop_busy_wr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && !acc_rw && busy |=> ac == $past(ac) && cg_sel == $past(cg_sel));

  p_status_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && !acc_rs && acc_rw |=> $stable(ac) && $stable(cg_sel));

  p_read_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && acc_rs && acc_rw |=> ac != $past(ac));

  p_write_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && acc_rs && !acc_rw && !busy |=> ac != $past(ac));

  p_cg_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cg_sel |-> ac[6] == 1'b0);

  p_one_line_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_sel && !two_line |-> ac <= 7'(2 * LINE_LEN - 1));

  p_two_line_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_sel && two_line |->
      (ac <= 7'(LINE_LEN - 1)) ||
      (ac >= 7'(LINE2_BASE) && ac <= 7'(LINE2_BASE + LINE_LEN - 1)));
endmodule

bind lcdh_host_if lcdh_host_if_chk #(
  .BUSY_CYC(BUSY_CYC), .LINE_LEN(LINE_LEN), .LINE2_BASE(LINE2_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_s), .acc_vld(acc_vld), .acc_rs(acc_rs),
  .acc_rw(acc_rw), .busy(busy), .ac(ac_q), .cg_sel(cg_q), .two_line(two_q)
);

// File: tb/sim_lcdh_host_if.sv
`timescale 1ns/1ps
module sim_lcdh_host_if;
  localparam int BUSY = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_vld, acc_rs, acc_rw;
  logic [7:0] acc_wdata;
  logic [7:0] acc_rdata;
  logic       busy;

  always #2 clk = ~clk;

  lcdh_host_if #(.BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_rs(acc_rs),
    .acc_rw(acc_rw), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .busy(busy)
  );

  int nchk = 0;
  int nerr = 0;
  int ncyc = 0;
  bit done = 0;

  // behavioural reference model
  int m_ac, m_cg, m_up, m_two, m_cnt, m_odr, m_ok;
  int ddm [128];
  bit ddk [128];
  int cgm [64];
  bit cgk [64];

  function automatic int nstep(int a, int up, int cg, int two);
    if (cg != 0) return up != 0 ? (a + 1) % 64 : (a + 63) % 64;
    if (two != 0) begin
      if (up != 0) return a == 39 ? 64 : (a == 103 ? 0 : a + 1);
      return a == 64 ? 39 : (a == 0 ? 103 : a - 1);
    end
    if (up != 0) return a == 79 ? 0 : a + 1;
    return a == 0 ? 79 : a - 1;
  endfunction

  task automatic load_odr(input int cg);
    if (cg != 0) begin m_odr = cgm[m_ac % 64]; m_ok = cgk[m_ac % 64]; end
    else         begin m_odr = ddm[m_ac];      m_ok = ddk[m_ac];      end
  endtask

  task automatic model_edge(input logic v, rs, rw, input logic [7:0] d);
    bit acc;
    acc = v && !rw && (m_cnt == 0);
    if (v && rs && rw) begin
      m_ac = nstep(m_ac, m_up, m_cg, m_two);
      load_odr(m_cg);
    end
    if (acc) begin
      if (rs) begin
        if (m_cg != 0) begin cgm[m_ac] = d; cgk[m_ac] = 1; end
        else           begin ddm[m_ac] = d; ddk[m_ac] = 1; end
        m_ac = nstep(m_ac, m_up, m_cg, m_two);
      end else if (d[7]) begin
        m_ac = d & 8'h7f; m_cg = 0; load_odr(0);
      end else if (d[6]) begin
        m_ac = d & 8'h3f; m_cg = 1; load_odr(1);
      end else if (d[5]) begin
        if (int'(d[3]) != m_two) foreach (ddk[i]) ddk[i] = 0;
        m_two = d[3];
      end else if (d[4]) begin
        if (!d[3]) begin
          m_ac = nstep(m_ac, d[2], m_cg, m_two);
          if (m_cg == 0) load_odr(0);
        end
      end else if (d[2]) begin
        m_up = d[1];
      end
    end
    if (acc) m_cnt = BUSY;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
  endtask

  task automatic cyc(input logic v, rs, rw, input logic [7:0] d, input string tag);
    int exp;
    @(negedge clk);
    acc_vld = v; acc_rs = rs; acc_rw = rw; acc_wdata = d;
    #1;
    nchk++;
    if (busy !== (m_cnt > 0)) begin
      nerr++;
      $display("FAIL R12 busy act %0b exp %0b", busy, m_cnt > 0);
    end
    if (v && rw) begin
      if (!rs) exp = ((m_cnt > 0) ? 128 : 0) | m_ac;
      else     exp = m_odr;
      if (!rs || m_ok != 0) begin
        nchk++;
        if (acc_rdata !== 8'(exp)) begin
          nerr++;
          $display("FAIL %s rdata act %02h exp %02h", tag, acc_rdata, 8'(exp));
        end
      end
    end
    model_edge(v, rs, rw, d);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 1'b0, 8'h00, tag);
  endtask

  task automatic wr(input logic rs, input logic [7:0] d, input string tag);
    cyc(1'b1, rs, 1'b0, d, tag);
    while (m_cnt > 0) idle("R12");
  endtask

  task automatic rd(input string tag);
    cyc(1'b1, 1'b1, 1'b1, 8'h00, tag);
  endtask

  task automatic st(input string tag);
    cyc(1'b1, 1'b0, 1'b1, 8'h00, tag);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000 && !done) begin
      nerr++;
      $display("FAIL R12 watchdog act running exp finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; acc_vld = 0; acc_rs = 0; acc_rw = 0; acc_wdata = 0;
    m_ac = 0; m_cg = 0; m_up = 1; m_two = 0; m_cnt = 0; m_odr = 0; m_ok = 1;
    foreach (ddk[i]) ddk[i] = 0;
    foreach (cgk[i]) cgk[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle("R1");
    st("R1");

    // one-line fill: counter wraps 0x4F -> 0x00
    wr(1'b0, 8'h80, "R3");
    for (int i = 0; i < 80; i++) wr(1'b1, 8'((i * 37 + 11) & 255), "R4");
    st("R7");

    // address set prefetch and consecutive reads
    wr(1'b0, 8'h90, "R3");
    for (int i = 0; i < 5; i++) rd("R9");
    st("R2");

    // write while busy is dropped
    cyc(1'b1, 1'b1, 1'b0, 8'h5a, "R4");
    cyc(1'b1, 1'b1, 1'b0, 8'ha5, "R13");
    cyc(1'b1, 1'b0, 1'b0, 8'h80, "R13");
    st("R2");
    while (m_cnt > 0) idle("R12");
    st("R13");

    // stale read after write
    wr(1'b0, 8'h85, "R3");
    rd("R9");
    wr(1'b1, 8'hc3, "R10");
    wr(1'b1, 8'h3c, "R10");
    rd("R10");
    rd("R10");

    // downward stepping, 0x00 -> 0x4F
    wr(1'b0, 8'h04, "R5");
    wr(1'b0, 8'h82, "R3");
    for (int i = 0; i < 4; i++) rd("R7");
    st("R5");

    // cursor moves and display shift
    wr(1'b0, 8'h14, "R11");
    st("R11");
    rd("R11");
    wr(1'b0, 8'h10, "R11");
    wr(1'b0, 8'h10, "R11");
    st("R11");
    rd("R11");
    wr(1'b0, 8'h18, "R11");
    st("R11");

    // two-line mode
    wr(1'b0, 8'h80, "R3");
    wr(1'b0, 8'h28, "R6");
    wr(1'b0, 8'h06, "R5");
    for (int i = 0; i < 80; i++) wr(1'b1, 8'((i * 53 + 7) & 255), "R6");
    st("R6");
    wr(1'b0, 8'ha5, "R3");
    for (int i = 0; i < 6; i++) rd("R6");
    st("R6");
    wr(1'b1, 8'h77, "R6");
    wr(1'b0, 8'he6, "R3");
    for (int i = 0; i < 3; i++) rd("R6");
    st("R6");
    wr(1'b0, 8'h04, "R5");
    wr(1'b0, 8'hc1, "R3");
    for (int i = 0; i < 4; i++) rd("R6");
    wr(1'b0, 8'h81, "R3");
    for (int i = 0; i < 4; i++) rd("R6");
    st("R6");

    // pattern store
    wr(1'b0, 8'h06, "R5");
    wr(1'b0, 8'h7e, "R3");
    for (int i = 0; i < 4; i++) wr(1'b1, 8'(i * 17 + 1), "R8");
    st("R8");
    wr(1'b0, 8'h7e, "R3");
    for (int i = 0; i < 4; i++) rd("R8");
    wr(1'b0, 8'h04, "R5");
    wr(1'b0, 8'h41, "R3");
    for (int i = 0; i < 3; i++) rd("R8");
    st("R8");
    wr(1'b0, 8'h14, "R11");
    st("R11");
    rd("R11");

    // other instruction and status during busy
    cyc(1'b1, 1'b0, 1'b0, 8'h0c, "R12");
    st("R2");
    idle("R12");
    st("R2");
    while (m_cnt > 0) idle("R12");
    idle("R12");
    finish_run();
  end
endmodule